// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the line and frame timing for a secondary display pipe. Software loads a handful of timing words through a simple write port: packed horizontal and vertical parameter words, packed sync-position words, a control word and a sync-control byte. From these the block runs a pixel counter and a line counter. It drives horizontal sync, vertical sync, blanking, display-enable and the current pixel and line coordinates. Sync polarity is programmable, and each sync can be forced to its idle level.

Every write lands in a shadow register. The timing words and the sync-control byte move into the working copy only at the edge where the frame wraps to pixel 0 of line 0. While the pipe is stopped they move in on every cycle. A frame therefore never mixes two parameter sets. The enable bit and the pixel-depth field of the control word act at once. The depth field is passed on unchanged to downstream fetch logic.

A two-state machine governs the pipe. In state ST_IDLE the counters sit at zero and the working copy tracks the shadow. Transition IDLE_TO_SCAN is taken when the enable bit is set. In state ST_SCAN the counters advance once per clock. Transition SCAN_TO_IDLE is taken as soon as the enable bit is cleared. Both states hold while the enable bit is unchanged.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the block is idle. Outputs: de=0, blank=1, hsync=0, vsync=0, pix_x=0, line_y=0, depth_code=0.
- R2: Write addresses are: 0 control, 1 horizontal parameter, 2 horizontal sync, 3 vertical parameter, 4 vertical sync, 5 sync-control (data bits 7:0). In each parameter word, bits 31:16 hold display-end and bits 15:0 hold total. In each sync word, bits 31:16 hold sync-end and bits 15:0 hold sync-start. Horizontal values are stored minus 8 and vertical values minus 1.
- R3: While scanning, pix_x counts 0 to htotal-1 and then wraps. Each wrap increments line_y, which counts 0 to vtotal-1 and wraps. The first edge after the enable bit is registered moves the pipe to ST_SCAN with both counters at 0. Counting starts on the edge after that.
- R4: de is 1 only while scanning with pix_x below horizontal display-end and line_y below vertical display-end. blank is always the inverse of de.
- R5: The raw horizontal sync is asserted for sync-start <= pix_x < sync-end. The raw vertical sync is asserted for sync-start <= line_y < sync-end.
- R6: Sync-control bit 6 makes hsync active-low and bit 7 makes vsync active-low. When a bit is clear, that sync is active-high.
- R7: Sync-control bit 4 holds hsync at its inactive level and bit 5 holds vsync at its inactive level, whatever the counters show.
- R8: Control bit 0 enables the pipe. One edge after a write clears it, the counters read 0, de=0, blank=1 and both syncs sit at their inactive level.
- R9: depth_code equals control bits 23:21 from the edge that registers the write. The encodings are 001 for 15 bpp, 010 for 16 bpp and 100 for 32 bpp.
- R10: Timing and sync-control writes made while scanning take effect only at the edge where the counters wrap to (0,0). While idle they take effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| hsync | output | 1 | Horizontal sync after polarity and gating |
| vsync | output | 1 | Vertical sync after polarity and gating |
| blank | output | 1 | Blanking, inverse of de |
| de | output | 1 | Display enable |
| pix_x | output | 17 | Current pixel counter |
| line_y | output | 17 | Current line counter |
| depth_code | output | 3 | Pixel-depth field of the control word |

## Verification
The bench uses the default 16-bit fields but programs a tiny raster: 20 pixels by 6 lines, later changed to 16 by 5. This makes each frame only about a hundred cycles. Every output is therefore compared on every cycle across many whole frames, covering all four combinations of sync polarity and gating. The second raster puts the sync end exactly at the total, so the sync holds to the last pixel before the wrap. Mid-frame rewrites of the timing and sync-control words expose the frame-boundary hand-over. Disabling and re-enabling the pipe exposes the idle-state loading.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    parameter int FIELD_W = 16;
    parameter int VAL_W   = FIELD_W + 1;
    parameter int ADDR_W  = 3;
    parameter int DATA_W  = 32;
    parameter int H_OFS   = 8;
    parameter int V_OFS   = 1;
    parameter int DEPTH_LSB = 21;
    parameter int DEPTH_W   = 3;
    parameter int NUM_AXES  = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_SCTL = 3'd5;

    localparam int BIT_EN     = 0;
    localparam int BIT_HS_OFF = 4;
    localparam int BIT_VS_OFF = 5;
    localparam int BIT_HS_LOW = 6;
    localparam int BIT_VS_LOW = 7;

    typedef struct packed {
        logic [VAL_W-1:0] total;
        logic [VAL_W-1:0] disp_end;
        logic [VAL_W-1:0] sync_start;
        logic [VAL_W-1:0] sync_end;
    } axis_t;

    typedef struct packed {
        axis_t h;
        axis_t v;
        logic  hs_low;
        logic  vs_low;
        logic  hs_off;
        logic  vs_off;
    } timing_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } pipe_state_t;

    function automatic logic [VAL_W-1:0] widen(input logic [FIELD_W-1:0] f, input int ofs);
        return {1'b0, f} + VAL_W'(ofs);
    endfunction

    function automatic axis_t unpack_axis(input logic [DATA_W-1:0] par,
                                          input logic [DATA_W-1:0] syn,
                                          input int ofs);
        axis_t a;
        a.total      = widen(par[FIELD_W-1:0], ofs);
        a.disp_end   = widen(par[DATA_W-1:FIELD_W], ofs);
        a.sync_start = widen(syn[FIELD_W-1:0], ofs);
        a.sync_end   = widen(syn[DATA_W-1:FIELD_W], ofs);
        return a;
    endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               load,
    output logic               ctrl_en,
    output logic [DEPTH_W-1:0] depth,
    output timing_t            active
);
    logic [DATA_W-1:0] par_sh [NUM_AXES];
    logic [DATA_W-1:0] syn_sh [NUM_AXES];
    axis_t             axis_dec [NUM_AXES];
    logic [3:0]        sctl_sh;
    timing_t           shadow_dec;
    timing_t           active_q;

    genvar a;
    generate
        for (a = 0; a < NUM_AXES; a++) begin : g_axis
            localparam logic [ADDR_W-1:0] ADR_PAR = ADDR_W'(1 + 2 * a);
            localparam logic [ADDR_W-1:0] ADR_SYN = ADDR_W'(2 + 2 * a);
            localparam int OFS = (a == 0) ? H_OFS : V_OFS;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    par_sh[a] <= '0;
                    syn_sh[a] <= '0;
                end else if (wr_en) begin
                    if (wr_addr == ADR_PAR) par_sh[a] <= wr_data;
                    if (wr_addr == ADR_SYN) syn_sh[a] <= wr_data;
                end
            end

            assign axis_dec[a] = unpack_axis(par_sh[a], syn_sh[a], OFS);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            depth   <= '0;
            sctl_sh <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_CTRL) begin
                ctrl_en <= wr_data[BIT_EN];
                depth   <= wr_data[DEPTH_LSB +: DEPTH_W];
            end
            if (wr_addr == ADR_SCTL) begin
                sctl_sh <= {wr_data[BIT_VS_LOW], wr_data[BIT_HS_LOW],
                            wr_data[BIT_VS_OFF], wr_data[BIT_HS_OFF]};
            end
        end
    end

    always_comb begin
        shadow_dec.h      = axis_dec[0];
        shadow_dec.v      = axis_dec[1];
        shadow_dec.hs_off = sctl_sh[0];
        shadow_dec.vs_off = sctl_sh[1];
        shadow_dec.hs_low = sctl_sh[2];
        shadow_dec.vs_low = sctl_sh[3];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q.h      <= unpack_axis('0, '0, H_OFS);
            active_q.v      <= unpack_axis('0, '0, V_OFS);
            active_q.hs_low <= 1'b0;
            active_q.vs_low <= 1'b0;
            active_q.hs_off <= 1'b0;
            active_q.vs_off <= 1'b0;
        end else if (load) begin
            active_q <= shadow_dec;
        end
    end

    assign active = active_q;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CTRL) |=> (depth == $past(wr_data[DEPTH_LSB +: DEPTH_W]))); // R9
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
    import rtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [VAL_W-1:0] htot,
    input  logic [VAL_W-1:0] vtot,
    output logic [VAL_W-1:0] h,
    output logic [VAL_W-1:0] v,
    output logic             running,
    output logic             load
);
    pipe_state_t state_q, state_d;
    logic [VAL_W-1:0] h_q, v_q;
    logic step, h_last, v_last, frame_wrap;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = en ? ST_SCAN : ST_IDLE;
            ST_SCAN: state_d = en ? ST_SCAN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running    = (state_q == ST_SCAN);
        step       = running && en;
        h_last     = (h_q == htot - 1'b1);
        v_last     = (v_q == vtot - 1'b1);
        frame_wrap = step && h_last && v_last;
        load       = (state_q == ST_IDLE) || frame_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else if (!step) begin
            h_q <= '0;
            v_q <= '0;
        end else if (h_last) begin
            h_q <= '0;
            v_q <= v_last ? '0 : v_q + 1'b1;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    assign h = h_q;
    assign v = v_q;

    AST_H_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (h_q < htot)); // R3
    AST_V_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (v_q < vtot)); // R3
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && h_last && !v_last) |=> (h_q == '0 && v_q == $past(v_q) + 1'b1)); // R3
    AST_IDLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (h_q == '0 && v_q == '0)); // R8
endmodule

// File: rtl/rtg_syncgen.sv
module rtg_syncgen
    import rtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [VAL_W-1:0] h,
    input  logic [VAL_W-1:0] v,
    input  timing_t          tm,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             blank
);
    logic h_in_sync, v_in_sync, hs_raw, vs_raw;

    always_comb begin
        h_in_sync = (h >= tm.h.sync_start) && (h < tm.h.sync_end);
        v_in_sync = (v >= tm.v.sync_start) && (v < tm.v.sync_end);
        hs_raw    = running && !tm.hs_off && h_in_sync;
        vs_raw    = running && !tm.vs_off && v_in_sync;
        hsync     = hs_raw ^ tm.hs_low;
        vsync     = vs_raw ^ tm.vs_low;
        de        = running && (h < tm.h.disp_end) && (v < tm.v.disp_end);
        blank     = !de;
    end

    AST_DE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!de && blank)); // R8
    AST_HS_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        tm.hs_off |-> (hsync == tm.hs_low)); // R7
    AST_VS_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        tm.vs_off |-> (vsync == tm.vs_low)); // R7
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               hsync,
    output logic               vsync,
    output logic               blank,
    output logic               de,
    output logic [VAL_W-1:0]   pix_x,
    output logic [VAL_W-1:0]   line_y,
    output logic [DEPTH_W-1:0] depth_code
);
    logic    ctrl_en, running, load;
    timing_t active;

    rtg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .ctrl_en (ctrl_en),
        .depth   (depth_code),
        .active  (active)
    );

    rtg_counters u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_en),
        .htot    (active.h.total),
        .vtot    (active.v.total),
        .h       (pix_x),
        .v       (line_y),
        .running (running),
        .load    (load)
    );

    rtg_syncgen u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .h       (pix_x),
        .v       (line_y),
        .tm      (active),
        .hsync   (hsync),
        .vsync   (vsync),
        .de      (de),
        .blank   (blank)
    );

    AST_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && (pix_x != '0 || line_y != '0)) |-> $stable(active)); // R10
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, blank, de;
    logic [16:0] pix_x, line_y;
    logic [2:0]  depth_code;

    int total = 0;
    int bad = 0;
    string sec = "R1";

    // bench model state
    logic [31:0] s_hpar = 0, s_hsyn = 0, s_vpar = 0, s_vsyn = 0;
    logic [7:0]  s_sctl = 0;
    logic [31:0] a_hpar = 0, a_hsyn = 0, a_vpar = 0, a_vsyn = 0;
    logic [7:0]  a_sctl = 0;
    logic [31:0] m_ctrl = 0;
    bit          m_run = 0;
    int          mh = 0, mv = 0;

    raster_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .blank(blank), .de(de),
        .pix_x(pix_x), .line_y(line_y), .depth_code(depth_code)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s [%s] %s: actual=%0d expected=%0d", req, sec, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        int htot, hde, hss, hse, vtot, vde, vss, vse;
        bit e_de, hs, vs;
        htot = int'(a_hpar[15:0]) + 8;  hde = int'(a_hpar[31:16]) + 8;
        hss  = int'(a_hsyn[15:0]) + 8;  hse = int'(a_hsyn[31:16]) + 8;
        vtot = int'(a_vpar[15:0]) + 1;  vde = int'(a_vpar[31:16]) + 1;
        vss  = int'(a_vsyn[15:0]) + 1;  vse = int'(a_vsyn[31:16]) + 1;
        e_de = m_run && mh < hde && mv < vde;
        hs = m_run && !a_sctl[4] && mh >= hss && mh < hse;
        vs = m_run && !a_sctl[5] && mv >= vss && mv < vse;
        hs = hs ^ a_sctl[6];
        vs = vs ^ a_sctl[7];
        chk("R3", int'(pix_x), mh, "pix_x");
        chk("R3", int'(line_y), mv, "line_y");
        chk("R4", int'(de), int'(e_de), "de");
        chk("R4", int'(blank), int'(!e_de), "blank");
        chk("R5", int'(hsync), int'(hs), "hsync");
        chk("R5", int'(vsync), int'(vs), "vsync");
        chk("R9", int'(depth_code), int'(m_ctrl[23:21]), "depth_code");
    endtask

    task automatic step();
        bit en;
        int htot, vtot;
        @(posedge clk);
        en = m_ctrl[0];
        htot = int'(a_hpar[15:0]) + 8;
        vtot = int'(a_vpar[15:0]) + 1;
        if (m_run && en) begin
            if (mh == htot - 1) begin
                mh = 0;
                if (mv == vtot - 1) begin
                    mv = 0;
                    a_hpar = s_hpar; a_hsyn = s_hsyn; a_vpar = s_vpar; a_vsyn = s_vsyn; a_sctl = s_sctl;
                end else mv = mv + 1;
            end else mh = mh + 1;
        end else begin
            mh = 0; mv = 0;
            if (!m_run) begin
                a_hpar = s_hpar; a_hsyn = s_hsyn; a_vpar = s_vpar; a_vsyn = s_vsyn; a_sctl = s_sctl;
            end
        end
        m_run = en;
        if (wr_en) begin
            case (wr_addr)
                3'd0: m_ctrl = wr_data;
                3'd1: s_hpar = wr_data;
                3'd2: s_hsyn = wr_data;
                3'd3: s_vpar = wr_data;
                3'd4: s_vsyn = wr_data;
                3'd5: s_sctl = wr_data[7:0];
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0;
        check_outputs();
    endtask

    task automatic wr(input logic [2:0] adr, input logic [31:0] d);
        wr_addr = adr;
        wr_data = d;
        wr_en   = 1'b1;
        step();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R3 watchdog expired: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(de), 0, "de");
        chk("R1", int'(blank), 1, "blank");
        chk("R1", int'(hsync), 0, "hsync");
        chk("R1", int'(vsync), 0, "vsync");
        chk("R1", int'(pix_x), 0, "pix_x");
        chk("R1", int'(line_y), 0, "line_y");
        chk("R1", int'(depth_code), 0, "depth_code");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: program 20x6 raster while idle, then enable
        sec = "R2";
        wr(3'd1, {16'd4, 16'd12});
        wr(3'd2, {16'd9, 16'd6});
        wr(3'd3, {16'd3, 16'd5});
        wr(3'd4, {16'd4, 16'd3});
        wr(3'd5, 32'h0);
        wr(3'd0, 32'h0020_0001);
        run(260);

        // R6 and R10: polarity change mid-frame waits for wrap
        sec = "R6";
        run(30);
        wr(3'd5, 32'hC0);
        run(250);
        wr(3'd5, 32'h40);
        run(250);

        // R7: sync gating at both polarities
        sec = "R7";
        wr(3'd5, 32'h30);
        run(250);
        wr(3'd5, 32'hF0);
        run(250);
        wr(3'd5, 32'h90);
        run(250);

        // R10: timing words rewritten mid-frame, 16x5 raster, sync to end of line
        sec = "R10";
        wr(3'd5, 32'h0);
        run(47);
        wr(3'd1, {16'd2, 16'd8});
        wr(3'd2, {16'd8, 16'd4});
        run(13);
        wr(3'd3, {16'd2, 16'd4});
        wr(3'd4, {16'd4, 16'd2});
        run(300);

        // R9: depth field follows control writes immediately
        sec = "R9";
        wr(3'd0, 32'h0080_0001);
        run(20);
        wr(3'd0, 32'h0040_0001);
        run(20);

        // R8: disable, reprogram while idle, re-enable
        sec = "R8";
        wr(3'd0, 32'h0040_0000);
        run(20);
        wr(3'd5, 32'hC0);
        run(5);
        wr(3'd1, {16'd4, 16'd12});
        wr(3'd2, {16'd9, 16'd6});
        wr(3'd3, {16'd3, 16'd5});
        wr(3'd4, {16'd4, 16'd3});
        run(3);
        wr(3'd0, 32'h0000_0001);
        run(260);
        wr(3'd0, 32'h0);
        run(10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule